// File: doc/BRIEF.md
# Split Instruction/Data Memory Protection Unit

This block sits beside a core that has separate instruction and data ports and decides, in the same cycle as each request, whether the access may proceed. It keeps two independent tables of address regions. Instruction fetches are checked only against the fetch table. Loads and stores are checked only against the data table. Each region has a base address, a power-of-two size, an enable bit and a permission code. Software sets all of these, plus a global protection switch, through a small synchronous register port.

While protection is on, a request that matches no enabled region of its own table aborts. A request that breaks the permissions of the region it matches also aborts. Each port has its own abort output, and the two ports never stall each other. The switch refuses to turn on unless both tables hold at least one enabled region. A refused request sets an error flag. The first abort is logged with its address and the port that caused it, and the log stays until software clears it.

Top module: `split_prot_unit`

## Requirements
- R1: A region with size code c covers 2^(c+1) bytes. Codes 4 to 31 give 32 B to 4 GB, and codes 0 to 3 behave as 4. An address matches when its bits above bit c agree with the base, so base bits below the region size are ignored.
- R2: Fetches are checked only against the instruction table, and loads and stores only against the data table. Both tables may cover the same range without raising the error flag.
- R3: While protection is on, a request whose address matches no enabled region of its table raises that port's abort in the same cycle as the request.
- R4: When several enabled regions of one table match, the highest-numbered one supplies the permission code.
- R5: Data permission codes are 00 no access, 01 read-only, 11 read/write, and 10 acts as no access. A write to a read-only region aborts and a read from it does not. A fetch is allowed by any nonzero code.
- R6: While protection is off, both abort outputs stay low for every request.
- R7: Writing control word 0 with bit0=1 turns protection on only if each table holds a region whose enable bit is set, and this clears the error flag. Otherwise the enable bit is left as it was and the error flag (bit1) is set. Writing bit0=0 turns protection off and clears the error flag.
- R8: The first abort while the log is empty captures the address (word 2) and sets word 1 to {port, valid}, where port is 0 for instruction and 1 for data. The log holds until any write to word 1. If both ports abort in the same cycle, the instruction side is recorded.
- R9: An abort output is high only while that port's request is high, and both ports are checked in the same cycle, each on its own.
- R10: Register map: word 0 control, word 1 fault status, word 2 fault address. Instruction region i has its base at 16+2i and its attributes at 17+2i. Data region i has its base at 32+2i and its attributes at 33+2i. The attribute layout is en bit0, perm bits 2:1, size bits 12:8. All registers read back what was written and reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 6 | Register word address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data (combinational) |
| i_req_i | input | 1 | Instruction fetch request |
| i_addr_i | input | 32 | Instruction fetch address |
| i_abort_o | output | 1 | Instruction fetch abort |
| d_req_i | input | 1 | Data access request |
| d_addr_i | input | 32 | Data access address |
| d_we_i | input | 1 | Data access is a write |
| d_abort_o | output | 1 | Data access abort |

## Verification
The assertions assume that the fault log is cleared only by a register write, that request and address inputs hold known values while a request is high, and that control writes reach only word 0. The bench changes every input half a cycle away from the clock edge. It drives one configuration write at a time and samples the aborts combinationally within the same request cycle. It reads the fault log only after the clock edge that follows the aborting request. Expected aborts come from a shadow copy of the regions the bench itself programmed.

// File: rtl/spu_pkg.sv
package spu_pkg;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 5;
  localparam logic [SIZE_W-1:0] SIZE_MIN = 5'd4;

  localparam logic [1:0] PERM_NONE = 2'b00;
  localparam logic [1:0] PERM_RO   = 2'b01;
  localparam logic [1:0] PERM_RW   = 2'b11;

  typedef enum logic [1:0] {
    SP_CTRL = 2'd0,
    SP_IREG = 2'd1,
    SP_DREG = 2'd2,
    SP_RSVD = 2'd3
  } cfg_space_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [SIZE_W-1:0] size;
    logic [1:0]        perm;
    logic              en;
  } region_t;

  // address bits that must agree with the base
  function automatic logic [ADDR_W-1:0] region_mask(input logic [SIZE_W-1:0] size);
    logic [SIZE_W-1:0] s;
    logic [ADDR_W:0]   lim;
    s   = (size < SIZE_MIN) ? SIZE_MIN : size;
    lim = (ADDR_W+1)'(1) << ({1'b0, s} + 6'd1);
    return ~(lim[ADDR_W-1:0] - 1'b1);
  endfunction

  function automatic logic [31:0] attr_word(input region_t r);
    return {19'b0, r.size, 5'b0, r.perm, r.en};
  endfunction
endpackage

// File: rtl/spu_region_bank.sv
module spu_region_bank
  import spu_pkg::*;
#(
  parameter int N_REGIONS = 8,
  localparam int IdxW = $clog2(N_REGIONS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [IdxW-1:0]           idx_i,
  input  logic                      attr_sel_i,
  input  logic [31:0]               wdata_i,
  output region_t [N_REGIONS-1:0]   regions_o,
  output logic                      any_valid_o
);
  region_t [N_REGIONS-1:0] regs_q;

  for (genvar g = 0; g < N_REGIONS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= '0;
      end else if (we_i && (idx_i == IdxW'(g))) begin
        if (attr_sel_i) begin
          regs_q[g].size <= wdata_i[12:8];
          regs_q[g].perm <= wdata_i[2:1];
          regs_q[g].en   <= wdata_i[0];
        end else begin
          regs_q[g].base <= wdata_i[ADDR_W-1:0];
        end
      end
    end
  end

  always_comb begin
    any_valid_o = 1'b0;
    for (int i = 0; i < N_REGIONS; i++) any_valid_o |= regs_q[i].en;
  end

  assign regions_o = regs_q;
endmodule

// File: rtl/spu_lookup.sv
module spu_lookup
  import spu_pkg::*;
#(
  parameter int N_REGIONS = 8
) (
  input  logic [ADDR_W-1:0]         addr_i,
  input  region_t [N_REGIONS-1:0]   regions_i,
  output logic                      hit_o,
  output logic [1:0]                perm_o
);
  // ascending scan: last (highest) match wins
  always_comb begin
    hit_o  = 1'b0;
    perm_o = PERM_NONE;
    for (int i = 0; i < N_REGIONS; i++) begin
      if (regions_i[i].en &&
          (((addr_i ^ regions_i[i].base) & region_mask(regions_i[i].size)) == '0)) begin
        hit_o  = 1'b1;
        perm_o = regions_i[i].perm;
      end
    end
  end
endmodule

// File: rtl/spu_ctrl.sv
module spu_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic i_any_i,
  input  logic d_any_i,
  output logic en_o,
  output logic err_o
);
  logic en_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      err_q <= 1'b0;
    end else if (wr_i) begin
      if (!wbit_i) begin
        en_q  <= 1'b0;
        err_q <= 1'b0;
      end else if (i_any_i && d_any_i) begin
        en_q  <= 1'b1;
        err_q <= 1'b0;
      end else begin
        err_q <= 1'b1;
      end
    end
  end

  assign en_o  = en_q;
  assign err_o = err_q;
endmodule

// File: rtl/spu_fault_log.sv
module spu_fault_log
  import spu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              i_abort_i,
  input  logic [ADDR_W-1:0] i_addr_i,
  input  logic              d_abort_i,
  input  logic [ADDR_W-1:0] d_addr_i,
  output logic              vld_o,
  output logic              port_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              vld_q, port_q;
  logic [ADDR_W-1:0] addr_q;
  logic              take;

  assign take = (i_abort_i || d_abort_i) && (!vld_q || clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      port_q <= 1'b0;
      addr_q <= '0;
    end else if (take) begin
      vld_q  <= 1'b1;
      port_q <= !i_abort_i;
      addr_q <= i_abort_i ? i_addr_i : d_addr_i;
    end else if (clr_i) begin
      vld_q  <= 1'b0;
      port_q <= 1'b0;
      addr_q <= '0;
    end
  end

  assign vld_o  = vld_q;
  assign port_o = port_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/split_prot_unit.sv
module split_prot_unit
  import spu_pkg::*;
#(
  parameter int N_REGIONS = 8,
  localparam int IdxW   = $clog2(N_REGIONS),
  localparam int CFG_AW = IdxW + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              i_req_i,
  input  logic [ADDR_W-1:0] i_addr_i,
  output logic              i_abort_o,
  input  logic              d_req_i,
  input  logic [ADDR_W-1:0] d_addr_i,
  input  logic              d_we_i,
  output logic              d_abort_o
);
  cfg_space_e             space;
  logic [IdxW-1:0]        idx;
  logic                   attr_sel;
  logic [IdxW:0]          sub;
  region_t [N_REGIONS-1:0] iregs, dregs;
  logic i_any_valid, d_any_valid;
  logic prot_en_q, prot_err_q;
  logic ctrl_wr, fault_clr;
  logic i_hit, d_hit, i_ok, d_ok;
  logic [1:0] i_perm, d_perm;
  logic fault_vld_q, fault_port_q;
  logic [ADDR_W-1:0] fault_addr_q;

  assign space    = cfg_space_e'(cfg_addr_i[CFG_AW-1 -: 2]);
  assign idx      = cfg_addr_i[IdxW:1];
  assign attr_sel = cfg_addr_i[0];
  assign sub      = cfg_addr_i[IdxW:0];

  assign ctrl_wr   = cfg_we_i && (space == SP_CTRL) && (sub == '0);
  assign fault_clr = cfg_we_i && (space == SP_CTRL) && (sub == (IdxW+1)'(1));

  spu_region_bank #(.N_REGIONS(N_REGIONS)) i_ibank (
    .clk_i, .rst_ni,
    .we_i       (cfg_we_i && (space == SP_IREG)),
    .idx_i      (idx),
    .attr_sel_i (attr_sel),
    .wdata_i    (cfg_wdata_i),
    .regions_o  (iregs),
    .any_valid_o(i_any_valid)
  );

  spu_region_bank #(.N_REGIONS(N_REGIONS)) i_dbank (
    .clk_i, .rst_ni,
    .we_i       (cfg_we_i && (space == SP_DREG)),
    .idx_i      (idx),
    .attr_sel_i (attr_sel),
    .wdata_i    (cfg_wdata_i),
    .regions_o  (dregs),
    .any_valid_o(d_any_valid)
  );

  spu_ctrl i_ctrl (
    .clk_i, .rst_ni,
    .wr_i   (ctrl_wr),
    .wbit_i (cfg_wdata_i[0]),
    .i_any_i(i_any_valid),
    .d_any_i(d_any_valid),
    .en_o   (prot_en_q),
    .err_o  (prot_err_q)
  );

  spu_lookup #(.N_REGIONS(N_REGIONS)) i_ilook (
    .addr_i(i_addr_i), .regions_i(iregs), .hit_o(i_hit), .perm_o(i_perm)
  );

  spu_lookup #(.N_REGIONS(N_REGIONS)) i_dlook (
    .addr_i(d_addr_i), .regions_i(dregs), .hit_o(d_hit), .perm_o(d_perm)
  );

  assign i_ok = i_hit && (i_perm != PERM_NONE);
  assign d_ok = d_hit && (d_we_i ? (d_perm == PERM_RW)
                                 : ((d_perm == PERM_RO) || (d_perm == PERM_RW)));

  assign i_abort_o = prot_en_q && i_req_i && !i_ok;
  assign d_abort_o = prot_en_q && d_req_i && !d_ok;

  spu_fault_log i_flog (
    .clk_i, .rst_ni,
    .clr_i    (fault_clr),
    .i_abort_i(i_abort_o),
    .i_addr_i (i_addr_i),
    .d_abort_i(d_abort_o),
    .d_addr_i (d_addr_i),
    .vld_o    (fault_vld_q),
    .port_o   (fault_port_q),
    .addr_o   (fault_addr_q)
  );

  always_comb begin
    cfg_rdata_o = '0;
    unique case (space)
      SP_CTRL: begin
        if (sub == '0)                   cfg_rdata_o = {30'b0, prot_err_q, prot_en_q};
        else if (sub == (IdxW+1)'(1))    cfg_rdata_o = {30'b0, fault_port_q, fault_vld_q};
        else if (sub == (IdxW+1)'(2))    cfg_rdata_o = fault_addr_q;
      end
      SP_IREG: cfg_rdata_o = attr_sel ? attr_word(iregs[idx]) : iregs[idx].base;
      SP_DREG: cfg_rdata_o = attr_sel ? attr_word(dregs[idx]) : dregs[idx].base;
      default: cfg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spu_chk.sv
module spu_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        prot_en,
  input logic        prot_err,
  input logic        i_any,
  input logic        d_any,
  input logic        ctrl_wr,
  input logic        ctrl_bit,
  input logic        i_req,
  input logic        i_abort,
  input logic        d_req,
  input logic        d_abort,
  input logic        fault_vld,
  input logic        fault_clr,
  input logic [31:0] fault_addr
);
  // R6
  disabled_no_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prot_en |-> (!i_abort && !d_abort));

  // R9
  i_abort_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i_abort |-> i_req);

  // R9
  d_abort_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_abort |-> d_req);

  // R7
  enable_needs_regions_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prot_en) |-> $past(i_any && d_any));

  // R7
  refused_sets_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && ctrl_bit && !(i_any && d_any)) |=> prot_err);

  // R8
  fault_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((i_abort || d_abort) && !fault_vld) |=> fault_vld);

  // R8
  fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_vld && !fault_clr) |=> (fault_vld && $stable(fault_addr)));
endmodule

bind split_prot_unit spu_chk i_spu_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .prot_en   (prot_en_q),
  .prot_err  (prot_err_q),
  .i_any     (i_any_valid),
  .d_any     (d_any_valid),
  .ctrl_wr   (ctrl_wr),
  .ctrl_bit  (cfg_wdata_i[0]),
  .i_req     (i_req_i),
  .i_abort   (i_abort_o),
  .d_req     (d_req_i),
  .d_abort   (d_abort_o),
  .fault_vld (fault_vld_q),
  .fault_clr (fault_clr),
  .fault_addr(fault_addr_q)
);

// File: tb/test_split_prot_unit.sv
module test_split_prot_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 8;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        i_req = 1'b0, d_req = 1'b0, d_we = 1'b0;
  logic [31:0] i_addr = '0, d_addr = '0;
  logic        i_abort, d_abort;

  int n_chk = 0, n_fail = 0;
  bit m_en = 0;
  logic [31:0] sh_base [2][NR];
  int          sh_size [2][NR];
  logic [1:0]  sh_perm [2][NR];
  bit          sh_en   [2][NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  split_prot_unit i_split_prot_unit (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .i_req_i(i_req), .i_addr_i(i_addr), .i_abort_o(i_abort),
    .d_req_i(d_req), .d_addr_i(d_addr), .d_we_i(d_we), .d_abort_o(d_abort)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic set_region(int side, int i, logic [31:0] base, int size, logic [1:0] perm, bit en);
    logic [5:0] w;
    w = 6'(16 + 16*side + 2*i);
    cfg_wr(w, base);
    cfg_wr(w + 6'd1, {19'b0, 5'(size), 5'b0, perm, en});
    sh_base[side][i] = base; sh_size[side][i] = size;
    sh_perm[side][i] = perm; sh_en[side][i] = en;
  endtask

  function automatic bit exp_abort(int side, logic [31:0] a, bit we);
    bit hit = 0;
    logic [1:0] p = 2'b00;
    int s;
    if (!m_en) return 1'b0;
    for (int i = 0; i < NR; i++) begin
      if (sh_en[side][i]) begin
        s = (sh_size[side][i] < 4) ? 4 : sh_size[side][i];
        if (((64'(a) ^ 64'(sh_base[side][i])) >> (s + 1)) == 64'd0) begin
          hit = 1; p = sh_perm[side][i];
        end
      end
    end
    if (!hit) return 1'b1;
    if (side == 0) return p == 2'b00;
    if (we) return p != 2'b11;
    return !(p == 2'b01 || p == 2'b11);
  endfunction

  // side 0 = fetch, 1 = data
  task automatic probe(string tag, int side, logic [31:0] a, bit we);
    @(negedge clk);
    i_req = (side == 0); d_req = (side == 1);
    i_addr = a; d_addr = a; d_we = we;
    #1;
    if (side == 0) chk(tag, {31'b0, i_abort}, {31'b0, exp_abort(0, a, 0)});
    else           chk(tag, {31'b0, d_abort}, {31'b0, exp_abort(1, a, we)});
  endtask

  task automatic idle();
    @(negedge clk);
    i_req = 1'b0; d_req = 1'b0; d_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < NR; i++) begin
        sh_base[s][i] = '0; sh_size[s][i] = 0; sh_perm[s][i] = '0; sh_en[s][i] = 0;
      end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R10 reset values
    cfg_rd(6'd0, rd);  chk("R10 ctrl reset", rd, 32'h0);
    cfg_rd(6'd1, rd);  chk("R10 status reset", rd, 32'h0);
    cfg_rd(6'd2, rd);  chk("R10 fault addr reset", rd, 32'h0);
    cfg_rd(6'd33, rd); chk("R10 data attr reset", rd, 32'h0);

    // R6 disabled: nothing aborts
    for (int k = 0; k < 8; k++) begin
      probe("R6 disabled fetch", 0, 32'h1234_0000 * k, 0);
      probe("R6 disabled write", 1, 32'h0ABC_0010 * k, 1);
    end
    idle();

    // R7 enable refused while tables empty
    cfg_wr(6'd0, 32'h1);
    cfg_rd(6'd0, rd); chk("R7 refused both empty", rd, 32'h2);
    set_region(0, 0, 32'hFFFF_FFE0, 4, 2'b01, 1);
    cfg_wr(6'd0, 32'h1);
    cfg_rd(6'd0, rd); chk("R7 refused data empty", rd, 32'h2);
    set_region(1, 0, 32'hFFFF_FFE0, 4, 2'b11, 1);
    cfg_wr(6'd0, 32'h1);
    m_en = 1;
    cfg_rd(6'd0, rd); chk("R7 accepted, R2 same range", rd, 32'h1);

    // R1 size sweep, both sides
    for (int c = 0; c < 32; c++) begin
      set_region(0, 1, 32'h0, c, 2'b01, 1);
      set_region(1, 1, 32'h0, c, 2'b01, 1);
      probe("R1 fetch last byte", 0, 32'((64'd2 << ((c < 4 ? 4 : c))) - 1), 0);
      probe("R1 fetch beyond", 0, 32'(64'd2 << ((c < 4 ? 4 : c))), 0);
      probe("R1 data last byte", 1, 32'((64'd2 << ((c < 4 ? 4 : c))) - 1), 0);
      probe("R1 data beyond", 1, 32'(64'd2 << ((c < 4 ? 4 : c))), 0);
    end
    // R1 low base bits ignored: base 0x1007 size 32 covers 0x1000..0x101F
    set_region(0, 1, 32'h0000_1007, 4, 2'b01, 1);
    probe("R1 unaligned base", 0, 32'h0000_1000, 0);
    @(negedge clk); #1 chk("R1 unaligned base low", {31'b0, i_abort}, 32'h0);
    probe("R1 unaligned base end", 0, 32'h0000_1020, 0);
    set_region(0, 1, 32'h0, 4, 2'b00, 0);
    set_region(1, 1, 32'h0, 4, 2'b00, 0);

    // overlapping tables for R2 R4 R5
    set_region(1, 2, 32'h000, 9, 2'b11, 1);
    set_region(1, 3, 32'h100, 7, 2'b01, 1);
    set_region(1, 5, 32'h180, 5, 2'b00, 1);
    set_region(1, 6, 32'h300, 4, 2'b10, 1);
    set_region(0, 2, 32'h200, 8, 2'b01, 1);
    set_region(0, 4, 32'h280, 4, 2'b00, 1);
    set_region(0, 7, 32'h000, 6, 2'b11, 1);
    cfg_rd(6'd0, rd); chk("R2 overlap no error", rd, 32'h1);
    for (int a = 0; a < 32'h800; a += 4) begin
      probe("R2 R3 R4 fetch sweep", 0, 32'(a), 0);
      probe("R4 R5 read sweep", 1, 32'(a), 0);
      probe("R4 R5 write sweep", 1, 32'(a), 1);
    end
    // explicit corner values
    probe("R4 none overrides", 1, 32'h190, 0);
    #0 chk("R4 none overrides abs", {31'b0, d_abort}, 32'h1);
    probe("R5 write read-only", 1, 32'h110, 1);
    #0 chk("R5 write RO abs", {31'b0, d_abort}, 32'h1);
    probe("R5 read read-only", 1, 32'h110, 0);
    #0 chk("R5 read RO abs", {31'b0, d_abort}, 32'h0);
    probe("R5 code10", 1, 32'h304, 0);
    #0 chk("R5 code10 abs", {31'b0, d_abort}, 32'h1);
    probe("R3 miss fetch", 0, 32'h0000_0900, 0);
    #0 chk("R3 miss fetch abs", {31'b0, i_abort}, 32'h1);
    idle();

    // R8 fault log
    cfg_wr(6'd1, 32'h0);
    cfg_rd(6'd1, rd); chk("R8 cleared", rd, 32'h0);
    probe("R8 fetch fault", 0, 32'h0000_0900, 0);
    idle();
    cfg_rd(6'd1, rd); chk("R8 status fetch", rd, 32'h1);
    cfg_rd(6'd2, rd); chk("R8 addr fetch", rd, 32'h900);
    probe("R8 second fault", 1, 32'h190, 0);
    idle();
    cfg_rd(6'd2, rd); chk("R8 addr held", rd, 32'h900);
    cfg_rd(6'd1, rd); chk("R8 status held", rd, 32'h1);
    cfg_wr(6'd1, 32'h0);
    // R9 both ports at once
    @(negedge clk);
    i_req = 1; d_req = 1; i_addr = 32'h904; d_addr = 32'hA00; d_we = 0;
    #1 chk("R9 dual fetch abort", {31'b0, i_abort}, 32'h1);
    chk("R9 dual data abort", {31'b0, d_abort}, 32'h1);
    idle();
    cfg_rd(6'd1, rd); chk("R8 dual keeps fetch", rd, 32'h1);
    cfg_rd(6'd2, rd); chk("R8 dual addr", rd, 32'h904);
    cfg_wr(6'd1, 32'h0);
    probe("R8 data fault", 1, 32'hA08, 1);
    idle();
    cfg_rd(6'd1, rd); chk("R8 status data", rd, 32'h3);
    cfg_rd(6'd2, rd); chk("R8 addr data", rd, 32'hA08);
    // R9 no request no abort
    @(negedge clk);
    i_req = 0; d_req = 0; i_addr = 32'hF00; d_addr = 32'hF00;
    #1 chk("R9 fetch idle", {31'b0, i_abort}, 32'h0);
    chk("R9 data idle", {31'b0, d_abort}, 32'h0);

    // R10 readback
    cfg_rd(6'd39, rd); chk("R10 data r3 attr", rd, 32'h0000_0703);
    cfg_rd(6'd38, rd); chk("R10 data r3 base", rd, 32'h100);
    cfg_rd(6'd25, rd); chk("R10 instr r4 attr", rd, 32'h0000_0401);

    // R6 and R7 disable
    cfg_wr(6'd0, 32'h0);
    m_en = 0;
    cfg_rd(6'd0, rd); chk("R7 disable", rd, 32'h0);
    probe("R6 after disable fetch", 0, 32'h900, 0);
    probe("R6 after disable write", 1, 32'h110, 1);
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule